// File: doc/BRIEF.md
# Interlaced Vertical Sync and Field Timing Generator

This block produces the vertical sync level and the field-identity level for a 625-line interlaced stream. A sync front end feeds it a line-start pulse, a mid-line pulse and a field-parity level. The block keeps its own frame line count, which it realigns on every rising parity edge. From that count it raises vertical sync on two fixed lines. It drops vertical sync and toggles the field level on lines derived from nominal reference lines, and software can shift those lines.

Each edge is set by an 8-bit control register. The register holds a 5-bit line offset, a direction bit that picks delay or advance, and two per-field enables. Each enable adds one more line of delay, either to the edge that closes the first field or to the edge that closes the second field, so the two fields can place their edges on different lines. A build-time option lets an advanced vertical-sync end move half a line earlier, timed by the mid-line pulse. Register writes are held in a shadow until the next field boundary. The same adjusted levels feed the output pins and the V/F flags that a downstream timing-code inserter uses.

Top module: `vsync_field_timer`

## Requirements
- R1: After reset, `vs_o`, `field_o`, `tc_v` and `tc_f` are 0. Register 0 (vertical-sync end, `cfg_addr`=0) reads 8'h14 and register 1 (field toggle, `cfg_addr`=1) reads 8'h63. Both registers use the layout bit 7 = first-field extra delay, bit 6 = second-field extra delay, bit 5 = direction (0 delay, 1 advance), bits 4:0 = offset.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` in the register picked by `cfg_addr`. `cfg_rdata` returns the stored contents of the register picked by `cfg_addr` one clock later.
- R3: The frame line count becomes 1 on a line-start pulse when `field_parity` is 1 and was 0 at the previous line start. Otherwise it advances by one and wraps from 625 to 1. Lines 1..312 form the first field and 313..625 the second.
- R4: `vs_o` rises one clock after the line-start pulse of line 623 or line 311.
- R5: With the direction bit at 0, `vs_o` falls one clock after the line-start pulse of line 23+offset in the first field and line 335+offset in the second field.
- R6: With the direction bit at 1, those vertical-sync end lines become 23-offset and 335-offset.
- R7: A set bit 7 adds one line to the first-field edge of its register, and a set bit 6 adds one line to the second-field edge of its register.
- R8: `field_o` toggles one clock after the line-start pulse of line 313 (closing the first field) and line 626 (closing the second field, which is line 1). Both lines are adjusted by the field-toggle register in the same way as R5 to R7.
- R9: Every adjusted line is reduced modulo 625 into 1..625.
- R10: When `VS_HALF_ADV` bit 1 (first field) or bit 0 (second field) is set and the direction bit is 1, that field's vertical-sync end moves to one clock after the mid-line pulse of the line before the adjusted line.
- R11: `vs_o` changes only one clock after a line-start or mid-line pulse, and `field_o` changes only one clock after a line-start pulse.
- R12: A register write affects the edges only from the next line start of line 1 or line 313. An edge on that boundary line still uses the previous setting.
- R13: `tc_v` always equals `vs_o` and `tc_f` always equals `field_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-clock pulse at the start of each line |
| half_line | input | 1 | One-clock pulse at the middle of each line |
| field_parity | input | 1 | 1 during the first field, 0 during the second |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 vertical-sync end, 1 field toggle |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| vs_o | output | 1 | Vertical sync level |
| field_o | output | 1 | Field identity level |
| tc_v | output | 1 | V flag for the timing-code inserter |
| tc_f | output | 1 | F flag for the timing-code inserter |

## Verification
The embedded assertions check the following on every clock:
- the line count stays inside the frame and moves only on line starts;
- the outputs move only right after a pulse;
- the active settings change only on a field boundary;
- every computed target line lies inside the frame;
- writes land in the addressed register.

Only the bench scenarios can show the line on which each edge actually falls. They run several register settings through whole frames and record where `vs_o` falls and `field_o` toggles. The scenarios cover both directions, both per-field enables, modulo wrap and the half-line option. They also show that a write made mid-field is deferred to the next boundary.

// File: rtl/vsft_pkg.sv
package vsft_pkg;

  // Field order follows the register bit positions: [7] first-field extra,
  // [6] second-field extra, [5] direction, [4:0] offset.
  typedef struct packed {
    logic       xtra_first;
    logic       xtra_second;
    logic       advance;
    logic [4:0] ofs;
  } edge_cfg_t;

  localparam int NUM_REGS = 2;
  localparam int REG_W    = 8;

endpackage

// File: rtl/vsft_cfg_regs.sv
module vsft_cfg_regs
  import vsft_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VS = 8'h14,
  parameter logic [REG_W-1:0] RST_FT = 8'h63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             load,
  output logic [REG_W-1:0] rdata,
  output edge_cfg_t        act_vs,
  output edge_cfg_t        act_ft
);

  logic [REG_W-1:0] prog_q [NUM_REGS];
  logic [REG_W-1:0] act_q  [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [REG_W-1:0] RV = (g == 0) ? RST_VS : RST_FT;

    always_ff @(posedge clk) begin
      if (rst) begin
        prog_q[g] <= RV;
      end else if (we && (addr == g[0])) begin
        prog_q[g] <= wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        act_q[g] <= RV;
      end else if (load) begin
        act_q[g] <= prog_q[g];
      end
    end

    // R2
    wr_take_chk: assert property (@(posedge clk) disable iff (rst)
      (we && (addr == g[0])) |=> (prog_q[g] == $past(wdata)));

    // R12
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(act_q[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= prog_q[addr];
    end
  end

  assign act_vs = edge_cfg_t'(act_q[0]);
  assign act_ft = edge_cfg_t'(act_q[1]);

endmodule

// File: rtl/vsft_line_track.sv
module vsft_line_track #(
  parameter int LINES = 625,
  localparam int LW   = $clog2(LINES + 1),
  localparam int HALF = LINES / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic          parity,
  output logic [LW-1:0] line_q,
  output logic [LW-1:0] line_nxt,
  output logic          boundary
);

  logic par_prev_q;
  logic resync;

  assign resync = parity && !par_prev_q;

  always_comb begin
    if (resync || (line_q == LW'(LINES))) begin
      line_nxt = LW'(1);
    end else begin
      line_nxt = line_q + LW'(1);
    end
  end

  assign boundary = line_start &&
                    ((line_nxt == LW'(1)) || (line_nxt == LW'(HALF + 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q     <= LW'(LINES);
      par_prev_q <= 1'b0;
    end else if (line_start) begin
      line_q     <= line_nxt;
      par_prev_q <= parity;
    end
  end

  // R3
  line_range_chk: assert property (@(posedge clk) disable iff (rst)
    (line_q >= LW'(1)) && (line_q <= LW'(LINES)));

  // R3
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(line_q));

endmodule

// File: rtl/vsft_edge_target.sv
module vsft_edge_target
  import vsft_pkg::*;
#(
  parameter int LINES       = 625,
  parameter int BASE_FIRST  = 23,
  parameter int BASE_SECOND = 335,
  localparam int LW         = $clog2(LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  edge_cfg_t            cfg,
  // index 1: edge in/closing the first field, index 0: the second field
  output logic [1:0][LW-1:0]   tgt,
  output logic [1:0][LW-1:0]   pre
);

  for (genvar f = 0; f < 2; f++) begin : g_fld
    localparam int BASE = (f == 1) ? BASE_FIRST : BASE_SECOND;
    logic xtra;
    int   sum;

    assign xtra = (f == 1) ? cfg.xtra_first : cfg.xtra_second;

    always_comb begin
      sum = BASE + LINES + int'(xtra);
      if (cfg.advance) begin
        sum = sum - int'(cfg.ofs);
      end else begin
        sum = sum + int'(cfg.ofs);
      end
      if (sum > LINES) sum = sum - LINES;
      if (sum > LINES) sum = sum - LINES;
      tgt[f] = LW'(sum);
      pre[f] = (sum == 1) ? LW'(LINES) : LW'(sum - 1);
    end

    // R9
    tgt_range_chk: assert property (@(posedge clk) disable iff (rst)
      (tgt[f] >= LW'(1)) && (tgt[f] <= LW'(LINES)));
  end

endmodule

// File: rtl/vsync_field_timer.sv
module vsync_field_timer
  import vsft_pkg::*;
#(
  parameter int               LINES        = 625,
  parameter int               VS_END_REF   = 23,
  parameter int               FT_REF       = 313,
  parameter int               VS_RISE_A    = 623,
  parameter int               VS_RISE_B    = 311,
  parameter logic [1:0]       VS_HALF_ADV  = 2'b00,
  parameter logic [REG_W-1:0] RST_VS_CFG   = 8'h14,
  parameter logic [REG_W-1:0] RST_FT_CFG   = 8'h63
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_start,
  input  logic       half_line,
  input  logic       field_parity,
  input  logic       cfg_we,
  input  logic       cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       vs_o,
  output logic       field_o,
  output logic       tc_v,
  output logic       tc_f
);

  localparam int LW   = $clog2(LINES + 1);
  localparam int HALF = LINES / 2;

  edge_cfg_t          act_vs, act_ft;
  logic [LW-1:0]      line_q, line_nxt;
  logic               boundary;
  logic [1:0][LW-1:0] vs_tgt, vs_pre, ft_tgt, ft_pre;
  logic [1:0]         half_en, hit_line, hit_half;
  logic               vs_set, vs_clr, ft_hit;
  logic               vs_q, field_q;

  vsft_cfg_regs #(.RST_VS(RST_VS_CFG), .RST_FT(RST_FT_CFG)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(boundary), .rdata(cfg_rdata), .act_vs(act_vs), .act_ft(act_ft)
  );

  vsft_line_track #(.LINES(LINES)) u_line (
    .clk(clk), .rst(rst), .line_start(line_start), .parity(field_parity),
    .line_q(line_q), .line_nxt(line_nxt), .boundary(boundary)
  );

  vsft_edge_target #(
    .LINES(LINES), .BASE_FIRST(VS_END_REF), .BASE_SECOND(VS_END_REF + HALF)
  ) u_vs_tgt (
    .clk(clk), .rst(rst), .cfg(act_vs), .tgt(vs_tgt), .pre(vs_pre)
  );

  vsft_edge_target #(
    .LINES(LINES), .BASE_FIRST(FT_REF), .BASE_SECOND(FT_REF + LINES - HALF)
  ) u_ft_tgt (
    .clk(clk), .rst(rst), .cfg(act_ft), .tgt(ft_tgt), .pre(ft_pre)
  );

  for (genvar f = 0; f < 2; f++) begin : g_vs_end
    assign half_en[f]  = act_vs.advance && VS_HALF_ADV[f];
    assign hit_line[f] = line_start && !half_en[f] && (line_nxt == vs_tgt[f]);
    assign hit_half[f] = half_line && half_en[f] && (line_q == vs_pre[f]);
  end

  assign vs_set = line_start &&
                  ((line_nxt == LW'(VS_RISE_A)) || (line_nxt == LW'(VS_RISE_B)));
  assign vs_clr = (|hit_line) || (|hit_half);
  assign ft_hit = line_start &&
                  ((line_nxt == ft_tgt[1]) || (line_nxt == ft_tgt[0]));

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q <= 1'b0;
    end else if (vs_clr) begin
      vs_q <= 1'b0;
    end else if (vs_set) begin
      vs_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= 1'b0;
    end else if (ft_hit) begin
      field_q <= ~field_q;
    end
  end

  assign vs_o    = vs_q;
  assign tc_v    = vs_q;
  assign field_o = field_q;
  assign tc_f    = field_q;

  // R11
  vs_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!line_start && !half_line) |=> $stable(vs_q));

  // R11
  fld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(field_q));

  // R10
  half_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (half_line && !act_vs.advance) |=> $stable(vs_q));

endmodule

// File: tb/vsync_field_timer_tb_top.sv
module vsync_field_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // cfg_vs, cfg_ft, vs fall 1st, vs fall 2nd, field toggle 1st, 2nd (occurrence order)
  localparam int VEC [NVEC][6] = '{
    '{8'h14, 8'h63, 43, 355, 310, 624},
    '{8'h05, 8'h00, 28, 340,   1, 313},
    '{8'hC5, 8'h85, 29, 341,   6, 319},
    '{8'h2A, 8'h42, 13, 325,   4, 315},
    '{8'hA3, 8'h3F, 21, 332, 282, 595},
    '{8'h5F, 8'hFF, 54, 367, 283, 596}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_start = 1'b0, half_line = 1'b0, field_parity = 1'b0;
  logic cfg_we = 1'b0, cfg_addr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] rdata_a, rdata_b;
  logic vs_a, fld_a, tcv_a, tcf_a, vs_b, fld_b, tcv_b, tcf_b;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int cur_line = 0;
  logic cur_half = 1'b0, measure = 1'b0;
  int ev_vs[4], ev_ft[4], ev_vs2[4];
  logic ev_vs2_h[4];
  int n_vs = 0, n_ft = 0, n_vs2 = 0, tc_bad = 0;
  logic vs_a_p = 1'b0, fld_a_p = 1'b0, vs_b_p = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsync_field_timer dut_i (
    .clk(clk), .rst(rst), .line_start(line_start), .half_line(half_line),
    .field_parity(field_parity), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_a), .vs_o(vs_a), .field_o(fld_a),
    .tc_v(tcv_a), .tc_f(tcf_a)
  );

  vsync_field_timer #(.VS_HALF_ADV(2'b11)) dut_half_i (
    .clk(clk), .rst(rst), .line_start(line_start), .half_line(half_line),
    .field_parity(field_parity), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_b), .vs_o(vs_b), .field_o(fld_b),
    .tc_v(tcv_b), .tc_f(tcf_b)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: sample two time units after each rising edge
  always @(posedge clk) begin
    #2;
    cycles++;
    if (!rst) begin
      if (measure) begin
        if (vs_a_p && !vs_a) begin
          if (n_vs < 4) ev_vs[n_vs] = cur_line;
          n_vs++;
        end
        if (fld_a_p != fld_a) begin
          if (n_ft < 4) ev_ft[n_ft] = cur_line;
          n_ft++;
        end
        if (vs_b_p && !vs_b) begin
          if (n_vs2 < 4) begin
            ev_vs2[n_vs2] = cur_line;
            ev_vs2_h[n_vs2] = cur_half;
          end
          n_vs2++;
        end
        if ((tcv_a != vs_a) || (tcf_a != fld_a) || (tcv_b != vs_b)) tc_bad++;
      end
      vs_a_p = vs_a; fld_a_p = fld_a; vs_b_p = vs_b;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        finish_run();
      end
    end
  end

  task automatic do_line(input int n);
    @(negedge clk);
    field_parity = (n <= 312);
    line_start = 1'b1; cur_line = n; cur_half = 1'b0;
    @(negedge clk);
    line_start = 1'b0;
    @(negedge clk);
    half_line = 1'b1; cur_half = 1'b1;
    @(negedge clk);
    half_line = 1'b0;
  endtask

  task automatic do_lines(input int a, input int b);
    for (int n = a; n <= b; n++) do_line(n);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output int v);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    v = int'(rdata_a);
  endtask

  task automatic clear_ev();
    n_vs = 0; n_ft = 0; n_vs2 = 0; tc_bad = 0;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(int'(vs_a), 0, "R1 vs_o reset");
    chk(int'(fld_a), 0, "R1 field_o reset");
    chk(int'(tcv_a) + int'(tcf_a), 0, "R1 tc flags reset");
    rd(1'b0, v); chk(v, 8'h14, "R1 vsync reg reset");
    rd(1'b1, v); chk(v, 8'h63, "R1 field reg reset");

    // R2: write / read back
    wr(1'b0, 8'h5A); rd(1'b0, v); chk(v, 8'h5A, "R2 readback reg0");
    wr(1'b1, 8'hA5); rd(1'b1, v); chk(v, 8'hA5, "R2 readback reg1");
    rd(1'b0, v); chk(v, 8'h5A, "R2 reg0 untouched by reg1 write");

    // vector table: R3 R4 R5 R6 R7 R8 R9 R10 R13
    for (int i = 0; i < NVEC; i++) begin
      int exp_l, exp_h;
      wr(1'b0, 8'(VEC[i][0]));
      wr(1'b1, 8'(VEC[i][1]));
      do_lines(1, 625);
      clear_ev();
      measure = 1'b1;
      do_lines(1, 625);
      measure = 1'b0;
      chk(n_vs, 2, "R4 R11 vs fall count");
      chk(ev_vs[0], VEC[i][2], "R5 R6 R7 vs end first field");
      chk(ev_vs[1], VEC[i][3], "R5 R6 R7 vs end second field");
      chk(n_ft, 2, "R8 R11 field toggle count");
      chk(ev_ft[0], VEC[i][4], "R8 R9 field toggle first");
      chk(ev_ft[1], VEC[i][5], "R8 R9 field toggle second");
      chk(tc_bad, 0, "R13 tc flags follow pins");
      chk(n_vs2, 2, "R10 half-line vs fall count");
      for (int k = 0; k < 2; k++) begin
        exp_l = VEC[i][2+k];
        exp_h = 0;
        if (VEC[i][0] & 8'h20) begin
          exp_l = exp_l - 1;
          exp_h = 1;
        end
        chk(ev_vs2[k], exp_l, "R10 half-line vs end line");
        chk(int'(ev_vs2_h[k]), exp_h, "R10 half-line position");
      end
    end

    // R12: mid-field write deferred to next boundary
    wr(1'b0, 8'h14);
    wr(1'b1, 8'h63);
    do_lines(1, 625);
    clear_ev();
    measure = 1'b1;
    do_lines(1, 20);
    wr(1'b0, 8'h1E);
    do_lines(21, 625);
    measure = 1'b0;
    chk(ev_vs[0], 43, "R12 old setting kept in current field");
    chk(ev_vs[1], 365, "R12 new setting from next field");

    // R4: vs high again after rise line 623
    do_line(1);
    chk(int'(vs_a), 1, "R4 vs high after line 623");

    finish_run();
  end

endmodule